// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block sits on the host side of an asynchronous DRAM with multiplexed row and column addresses. It turns word-wide read and write requests into strobe sequences on the row strobe, column strobe, write enable and output enable pins. Every strobe change is a whole number of clock cycles, and each timing limit is a parameter counted in cycles. After an access the row stays open. A later request to the same row then costs only one column cycle. A request to another row first closes the page, waits out the precharge and then opens the new row.

A counter tracks how long the row strobe has been low. It closes the page early enough that the row-active limit is never exceeded, even when requests keep hitting the open row or none arrive at all. A separate refresh engine asks for the memory through a request/grant pair. The grant is given only while no page is open. Writes use the early-write form: write enable falls before the column strobe, and the data pins are driven only during that cycle. A read samples the data pins when the column-strobe access count expires and returns the byte with a one-cycle valid pulse.

Requests use a valid/ready handshake. The requester holds `req_valid` and the request fields steady until a cycle in which `req_ready` is high. The transfer happens on that clock edge. `req_ready` is high only when the controller is idle with no page open, or when a page is open, no column cycle is running and the page is not due to close. It is low whenever `ref_req` is high. Responses have no back-pressure: each read produces exactly one `rsp_valid` pulse, in request order.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, all four strobes are high, `dram_dq_oe` is low, `rsp_valid` and `ref_gnt` are low, and `req_ready` is high.
- R2: A request address splits into a row from the upper `P_ROW_W` bits and a column from the lower `P_COL_W` bits. The row appears on `dram_a` at least one cycle before the row strobe falls. The column appears on `dram_a`, with its unused upper pins at zero, at least one cycle before the column strobe falls.
- R3: Requests to the row that is already open issue only a new column-strobe pulse, without another row activation. Reads and writes may be mixed in any order within the page.
- R4: A request to a different row raises the row strobe and keeps it high for at least `P_T_RP`+1 cycles before the new row opens. Every row activation has this minimum high time before it.
- R5: The row strobe is never low for more than `P_RAS_MAX_CYC` cycles in one activation. This holds both when hits keep arriving and when the open page sits idle.
- R6: Write (`req_write`=1): write enable is low at least one cycle before the column strobe falls. While the column strobe is low, `dram_dq_oe` is high with the request data on `dram_dq_out`, and output enable is high.
- R7: Read (`req_write`=0): write enable is high, output enable is low and `dram_dq_oe` is low when the column strobe falls. `dram_dq_in` is sampled when the column strobe rises, and `rsp_rdata` carries that value during a single-cycle `rsp_valid` pulse. Responses come in request order.
- R8: A request is taken exactly when `req_valid` and `req_ready` are both high at a clock edge, and each request taken produces exactly one column cycle. `req_ready` is low whenever `ref_req` is high or a column cycle is in progress.
- R9: `ref_gnt` goes high only while the row and column strobes are both high. It closes an open page first, stays high while `ref_req` stays high, and drops on the clock edge after `ref_req` falls.
- R10: The column strobe falls only while the row strobe is low. Row-to-column delay is at least `P_T_RCD`+1 cycles. Each column-strobe low time is at least `P_T_CAS` cycles. Column-strobe high time between pulses is at least `P_T_CP`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | P_ROW_W+P_COL_W | Word address, row in upper bits |
| req_wdata | input | P_DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | P_DATA_W | Read data |
| ref_req | input | 1 | Refresh engine asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh engine |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | P_ROW_W | Multiplexed address pins |
| dram_dq_out | output | P_DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for the data pads |
| dram_dq_in | input | P_DATA_W | Data from the memory |

## Verification
A wrong stored row shows within one request. A hit on the wrong row lands data at a location the bench memory model does not expect, and a needless miss adds row activations beyond the count the bench predicts for each access order. A sequencing or timer fault moves a strobe edge by a cycle. The bench checks that edge at the next strobe fall or rise: address setup, row-to-column delay, precharge length and column pulse widths. A runaway row-active count is caught when the row strobe rises. A grant given over an open page is caught in the cycle it appears.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROWSET,
    S_RCD,
    S_COLSET,
    S_CASLO,
    S_CASPRE,
    S_OPEN,
    S_PRE,
    S_REF
  } fpm_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
  parameter int P_ROW_W = 11,
  parameter int P_COL_W = 10
) (
  input  logic [P_ROW_W+P_COL_W-1:0] addr,
  output logic [P_ROW_W-1:0]         row,
  output logic [P_ROW_W-1:0]         col_pin
);

  assign row = addr[P_ROW_W+P_COL_W-1:P_COL_W];

  // column is narrower than the pin bus: unused upper pins held at zero
  generate
    if (P_ROW_W > P_COL_W) begin : g_pad
      assign col_pin = {{(P_ROW_W-P_COL_W){1'b0}}, addr[P_COL_W-1:0]};
    end else begin : g_same
      assign col_pin = addr[P_COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int P_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [P_W-1:0] load_val,
  output logic           zero
);

  logic [P_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R10: a running wait only ever counts down by one
  p_tmr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
  parameter int P_MAX    = 5000,
  parameter int P_MARGIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic close_due
);

  localparam int CNT_W = $clog2(P_MAX + 2);
  localparam int LIMIT = P_MAX - P_MARGIN;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (!ras_low)                    cnt_q <= '0;
    else if (cnt_q != CNT_W'(P_MAX + 1))  cnt_q <= cnt_q + 1'b1;
  end

  assign close_due = (cnt_q >= CNT_W'(LIMIT));

  // R5: the FSM must have raised the row strobe before the window is spent
  p_ras_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(P_MAX));

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int P_ROW_W       = 11,
  parameter int P_COL_W       = 10,
  parameter int P_DATA_W      = 8,
  parameter int P_T_RP        = 2,
  parameter int P_T_RCD       = 1,
  parameter int P_T_CAS       = 1,
  parameter int P_T_CP        = 1,
  parameter int P_RAS_MAX_CYC = 5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [P_ROW_W+P_COL_W-1:0] req_addr,
  input  logic [P_DATA_W-1:0]        req_wdata,
  output logic                       rsp_valid,
  output logic [P_DATA_W-1:0]        rsp_rdata,
  input  logic                       ref_req,
  output logic                       ref_gnt,
  output logic                       dram_ras_n,
  output logic                       dram_cas_n,
  output logic                       dram_we_n,
  output logic                       dram_oe_n,
  output logic [P_ROW_W-1:0]         dram_a,
  output logic [P_DATA_W-1:0]        dram_dq_out,
  output logic                       dram_dq_oe,
  input  logic [P_DATA_W-1:0]        dram_dq_in
);

  localparam int TMAX   = max4(P_T_RP, P_T_RCD, P_T_CAS, P_T_CP);
  localparam int TMR_W  = (TMAX < 2) ? 1 : $clog2(TMAX);
  // worst-case cycles between the last accepted request and the row strobe rising
  localparam int MARGIN = P_T_RCD + P_T_CAS + P_T_CP + 4;

  fpm_state_e state_q;

  logic [P_ROW_W-1:0]  req_row, req_col_pin;
  logic [P_ROW_W-1:0]  row_q, col_q;
  logic                wr_q, pend_q;
  logic [P_DATA_W-1:0] wdata_q;
  logic                hit, acc, close_due;
  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;

  fpm_addr_split #(.P_ROW_W(P_ROW_W), .P_COL_W(P_COL_W)) u_split (
    .addr    (req_addr),
    .row     (req_row),
    .col_pin (req_col_pin)
  );

  fpm_timer #(.P_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  fpm_ras_guard #(.P_MAX(P_RAS_MAX_CYC), .P_MARGIN(MARGIN)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_low   (!dram_ras_n),
    .close_due (close_due)
  );

  assign hit       = (req_row == row_q);
  assign req_ready = !ref_req &&
                     ((state_q == S_IDLE) || (state_q == S_OPEN && !close_due));
  assign acc       = req_valid && req_ready;

  // wait counts are loaded on the edge that enters the waiting state
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_ROWSET: begin tmr_load = 1'b1; tmr_val = TMR_W'(P_T_RCD - 1); end
      S_COLSET: begin tmr_load = 1'b1; tmr_val = TMR_W'(P_T_CAS - 1); end
      S_CASLO:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TMR_W'(P_T_CP - 1); end
      S_OPEN:   if (ref_req || close_due || (acc && !hit)) begin
                  tmr_load = 1'b1; tmr_val = TMR_W'(P_T_RP - 1);
                end
      S_REF:    if (!ref_req) begin tmr_load = 1'b1; tmr_val = TMR_W'(P_T_RP - 1); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_a      <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      pend_q      <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      ref_gnt     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (acc) begin
        col_q   <= req_col_pin;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      unique case (state_q)
        S_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            state_q <= S_REF;
          end else if (acc) begin
            dram_a  <= req_row;
            row_q   <= req_row;
            state_q <= S_ROWSET;
          end
        end
        S_ROWSET: begin
          dram_ras_n <= 1'b0;
          state_q    <= S_RCD;
        end
        S_RCD: begin
          if (tmr_zero) begin
            dram_a      <= col_q;
            dram_we_n   <= !wr_q;
            dram_oe_n   <= wr_q;
            dram_dq_out <= wdata_q;
            dram_dq_oe  <= wr_q;
            state_q     <= S_COLSET;
          end
        end
        S_COLSET: begin
          dram_cas_n <= 1'b0;
          state_q    <= S_CASLO;
        end
        S_CASLO: begin
          if (tmr_zero) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            state_q <= S_CASPRE;
          end
        end
        S_CASPRE: begin
          if (tmr_zero) state_q <= S_OPEN;
        end
        S_OPEN: begin
          if (ref_req || close_due) begin
            dram_ras_n <= 1'b1;
            pend_q     <= 1'b0;
            state_q    <= S_PRE;
          end else if (acc) begin
            if (hit) begin
              dram_a      <= req_col_pin;
              dram_we_n   <= !req_write;
              dram_oe_n   <= req_write;
              dram_dq_out <= req_wdata;
              dram_dq_oe  <= req_write;
              state_q     <= S_COLSET;
            end else begin
              dram_ras_n <= 1'b1;
              dram_a     <= req_row;
              row_q      <= req_row;
              pend_q     <= 1'b1;
              state_q    <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (tmr_zero) begin
            pend_q  <= 1'b0;
            state_q <= pend_q ? S_ROWSET : S_IDLE;
          end
        end
        S_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            state_q <= S_PRE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9: memory handed over only with both strobes inactive
  p_gnt_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n));

  // R10: column strobe only inside an active row
  p_cas_in_ras_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  // R2: address settled a cycle ahead of either strobe falling
  p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_a));
  p_col_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_a));

  // R4: a rising row strobe stays high for more than one cycle
  p_pre_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);

  // R6: early write and pad drive only for writes
  p_we_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));
  p_dq_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));

  // R7: reads have output enable on, responses are single pulses
  p_read_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && dram_we_n) |-> !dram_oe_n);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;

  localparam int RW   = 3;
  localparam int CW   = 2;
  localparam int DW   = 8;
  localparam int TRP  = 2;
  localparam int TRCD = 1;
  localparam int TCAS = 1;
  localparam int TCP  = 1;
  localparam int RMAX = 30;
  localparam int AW   = RW + CW;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          ref_req, ref_gnt;
  logic          dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [RW-1:0] dram_a;
  logic [DW-1:0] dram_dq_out, dram_dq_in;
  logic          dram_dq_oe;

  fpm_dram_ctrl #(
    .P_ROW_W(RW), .P_COL_W(CW), .P_DATA_W(DW), .P_T_RP(TRP), .P_T_RCD(TRCD),
    .P_T_CAS(TCAS), .P_T_CP(TCP), .P_RAS_MAX_CYC(RMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_a(dram_a), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  logic [DW-1:0] mem    [NLOC];
  logic [DW-1:0] shadow [NLOC];
  logic [DW-1:0] exp_q  [256];
  int n_chk = 0, n_err = 0;
  int acts = 0, casf = 0, n_wr_seen = 0, n_rd_seen = 0, issued = 0;
  int wp = 0, rp = 0;
  bit done = 1'b0;

  // memory model state
  logic          prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [RW-1:0] prev_a = '0, row_lat = '0;
  logic [CW-1:0] col_lat = '0;
  int hi_cnt = 1000, lo_cnt = 0, since_ras = 0, cas_hi = 1000, cas_lo = 0;
  bit first_cas = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'(a * 29 + seed * 71 + 5);
  endfunction

  assign dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                      ? mem[{row_lat, col_lat}] : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        acts++;
        chk(dram_a == prev_a, "R2 row setup", int'(dram_a), int'(prev_a));
        chk(hi_cnt >= TRP + 1, "R4 precharge cycles", hi_cnt, TRP + 1);
        row_lat   = dram_a;
        since_ras = 0;
        first_cas = 1'b1;
      end else if (!dram_ras_n) begin
        since_ras++;
      end
      if (!prev_ras && dram_ras_n)
        chk(lo_cnt <= RMAX, "R5 row active window", lo_cnt, RMAX);
      if (dram_ras_n) begin hi_cnt++; lo_cnt = 0; end
      else            begin lo_cnt++; hi_cnt = 0; end

      if (prev_cas && !dram_cas_n) begin
        casf++;
        chk(!dram_ras_n, "R10 column strobe inside row", int'(dram_ras_n), 0);
        chk(dram_a == prev_a, "R2 column setup", int'(dram_a), int'(prev_a));
        chk(dram_a[RW-1:CW] == '0, "R2 unused column pins", int'(dram_a[RW-1:CW]), 0);
        if (first_cas)
          chk(since_ras >= TRCD + 1, "R10 row to column delay", since_ras, TRCD + 1);
        first_cas = 1'b0;
        chk(cas_hi >= TCP + 1, "R10 column precharge", cas_hi, TCP + 1);
        col_lat = dram_a[CW-1:0];
        if (!dram_we_n) begin
          chk(!prev_we, "R6 write enable before column strobe", int'(prev_we), 0);
          chk(dram_dq_oe, "R6 data driven", int'(dram_dq_oe), 1);
          chk(dram_oe_n, "R6 output enable high", int'(dram_oe_n), 1);
          mem[{row_lat, col_lat}] = dram_dq_out;
          n_wr_seen++;
        end else begin
          chk(!dram_oe_n, "R7 output enable low", int'(dram_oe_n), 0);
          chk(!dram_dq_oe, "R7 data pads released", int'(dram_dq_oe), 0);
          n_rd_seen++;
        end
      end
      if (!prev_cas && dram_cas_n)
        chk(cas_lo >= TCAS, "R10 column strobe width", cas_lo, TCAS);
      if (dram_cas_n) begin cas_hi++; cas_lo = 0; end
      else            begin cas_lo++; cas_hi = 0; end

      if (ref_gnt)
        chk(dram_ras_n && dram_cas_n, "R9 grant with page closed",
            int'({dram_ras_n, dram_cas_n}), 3);

      if (rsp_valid) begin
        chk(rp < wp, "R7 response without read", rp, wp);
        if (rp < wp) begin
          chk(rsp_rdata == exp_q[rp], "R7 read data", int'(rsp_rdata), int'(exp_q[rp]));
          rp++;
        end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_we  = dram_we_n;
      prev_a   = dram_a;
    end
  end

  task automatic issue(input bit wr, input int addr, input logic [DW-1:0] d);
    req_write = wr;
    req_addr  = AW'(addr);
    req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    issued++;
    if (wr) shadow[addr] = d;
    else begin exp_q[wp] = shadow[addr]; wp++; end
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int a0, c0, k;
    for (int i = 0; i < NLOC; i++) begin mem[i] = '0; shadow[i] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; ref_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes after reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R1 drive and strobes idle",
        int'({dram_dq_oe, rsp_valid, ref_gnt}), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // sequential writes: one activation per row (R3)
    a0 = acts;
    for (int i = 0; i < NLOC; i++) issue(1'b1, i, pat(i, 1));
    drain();
    chk(acts - a0 == NLOC / 4, "R3 activations for sequential writes", acts - a0, NLOC / 4);
    for (int i = 0; i < NLOC; i++)
      chk(mem[i] == pat(i, 1), "R2 address mapping", int'(mem[i]), int'(pat(i, 1)));

    // row-stride reads: every request misses (R4)
    a0 = acts;
    for (int i = 0; i < NLOC; i++) issue(1'b0, (i % 8) * 4 + i / 8, '0);
    drain();
    chk(acts - a0 == NLOC, "R4 activations for row-stride reads", acts - a0, NLOC);

    // mixed reads and writes inside one page (R3)
    a0 = acts;
    issue(1'b1, 23, pat(23, 2));
    issue(1'b0, 23, '0);
    issue(1'b1, 20, pat(20, 2));
    issue(1'b0, 22, '0);
    issue(1'b0, 20, '0);
    drain();
    chk(acts - a0 == 1, "R3 mixed page single activation", acts - a0, 1);

    // idle open page must close by itself (R5)
    issue(1'b0, 7, '0);
    repeat (RMAX + 5) @(negedge clk);
    chk(dram_ras_n, "R5 idle page closed", int'(dram_ras_n), 1);

    // unbroken hits still force a close (R5)
    a0 = acts;
    for (int i = 0; i < 24; i++) issue(1'b0, 8 + (i % 4), '0);
    drain();
    chk(acts - a0 >= 2, "R5 hit stream reopened", acts - a0, 2);

    // refresh while a page is open (R9)
    issue(1'b0, 13, '0);
    repeat (3) @(negedge clk);
    ref_req = 1'b1;
    #1;
    chk(!req_ready, "R8 ready low under refresh request", int'(req_ready), 0);
    k = 0;
    while (!ref_gnt && k < 50) begin @(negedge clk); k++; end
    chk(ref_gnt, "R9 grant given", int'(ref_gnt), 1);
    chk(dram_ras_n && dram_cas_n, "R9 page closed at grant",
        int'({dram_ras_n, dram_cas_n}), 3);
    repeat (5) @(negedge clk);
    chk(ref_gnt, "R9 grant held", int'(ref_gnt), 1);
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_gnt, "R9 grant released", int'(ref_gnt), 0);

    // back-pressure: request held while refresh owns the memory (R8)
    ref_req = 1'b1;
    while (!ref_gnt) @(negedge clk);
    c0 = casf;
    req_write = 1'b1; req_addr = AW'(30); req_wdata = 8'h5A; req_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!req_ready, "R8 ready stays low", int'(req_ready), 0);
    end
    chk(casf == c0, "R8 no column cycle while blocked", casf - c0, 0);
    ref_req = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    issued++;
    shadow[30] = 8'h5A;
    drain();
    chk(mem[30] == 8'h5A, "R8 held request written once", int'(mem[30]), 'h5A);

    // read back everything in address order
    for (int i = 0; i < NLOC; i++) issue(1'b0, i, '0);
    drain();

    chk(n_wr_seen + n_rd_seen == issued, "R8 one column cycle per request",
        n_wr_seen + n_rd_seen, issued);
    chk(rp == wp, "R7 one response per read", rp, wp);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule